// File: doc/BRIEF.md
# Run-Time Configurable Pseudo-Random Bit Stepper

This block produces a pseudo-random bit stream from a shift register whose length (2 to 16 bits), feedback tap set and feedback structure are chosen at run time. The structure is either an external XOR chain that builds one feedback bit for the top stage, or an internal XOR chain that flips interior stages when a 1 leaves the register. The register always shifts toward the least significant bit. The stage at position 1 acts as the output stage and is always a feedback tap, even when the tap vector does not name it.

Software-style use is simple. The host presents a length, a tap vector, a structure select and a seed, and then pulses `load`. The block checks the whole set. If the set is legal, it is latched and the seed becomes the state. If not, nothing is latched and an error flag rises. Each later `step` pulse advances the register by one position and presents the bit that left it. The state is visible on the ports at all times.

Top module: `lfsr_stepper`

## Requirements
- R1: After reset, `state` is 0, `err` is 0, `bit_vld` is 0, and the block counts as unloaded.
- R2: A `load` with a legal set puts `seed` on `state` at the next edge, clears `err`, and latches `len`, `taps` and `galois` for later steps.
- R3: A `load` whose seed is 0, or has any bit set at index `len` or above (seed greater than 2^len-1), sets `err`, and `state` keeps its previous value.
- R4: A `load` whose `len` lies outside 2..16, whose tap vector has bit `len`-1 clear, or whose tap vector has any bit set at index `len` or above, sets `err` and leaves `state` unchanged. Tap vector encoding: bit t-1 stands for position t. Bit 0 is ignored, because position 1 is always a tap.
- R5: A `step` while `err` is set, or before any legal load since reset, does not change `state`, and `bit_vld` stays 0.
- R6: An accepted `step` raises `bit_vld` for exactly the next cycle. In that cycle `bit_out` equals bit 0 of `state` as it stood before the step.
- R7: With `galois`=0 the feedback bit is the XOR of state bit t-1 over position 1 and every tap t. The new state is the old state shifted right by one, with the feedback bit placed at bit `len`-1.
- R8: With `galois`=1 the state shifts right by one. If the bit that left was 1, the state is also XORed with a mask that has bit t-1 set for every tap t from 2 to `len`.
- R9: Changes on `len`, `taps` or `galois` between loads have no effect on stepping until the next legal load.
- R10: When `load` and `step` are high in the same cycle, only the load acts and `bit_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len | input | 5 | Register length, sampled on load |
| taps | input | 16 | Tap vector, bit t-1 for position t, sampled on load |
| galois | input | 1 | 1 selects internal XOR, 0 selects external XOR, sampled on load |
| seed | input | 16 | Initial state, sampled on load |
| load | input | 1 | Check the set and apply it when legal |
| step | input | 1 | Advance the register by one position |
| state | output | 16 | Current register contents |
| bit_out | output | 1 | Bit shifted out by the last accepted step |
| bit_vld | output | 1 | One-cycle qualifier for `bit_out` |
| err | output | 1 | Last load was rejected |

## Verification
A wrong internal value shows on `state` one cycle after the step that produced it, because the state register drives the port directly. The bench compares `state`, `bit_out`, `bit_vld` and `err` to a reference model in every cycle. A corrupted tap mask or feedback bit therefore shows up on the first step where a tap bit or the dropped bit matters. This is normally within a few steps of a load. A latched length or structure that was lost appears as a divergence in the top stage on the first step. Wrong legality decisions appear on `err` and on `state` one cycle after the load.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int MAX_W = 16;
  localparam int LEN_W = $clog2(MAX_W + 1);

  typedef logic [MAX_W-1:0] word_t;
  typedef logic [LEN_W-1:0] len_t;

  // ones in the low n bits (n may be 0..MAX_W or larger)
  function automatic word_t active_mask(input len_t n);
    word_t m;
    for (int i = 0; i < MAX_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  // single one at bit n-1, zero when n is 0 or too large
  function automatic word_t top_bit(input len_t n);
    word_t m;
    for (int i = 0; i < MAX_W; i++) m[i] = (i + 1 == int'(n));
    return m;
  endfunction
endpackage

// File: rtl/lfsr_cfg_check.sv
module lfsr_cfg_check
  import lfsr_pkg::*;
(
  input  len_t  len_i,
  input  word_t taps_i,
  input  word_t seed_i,
  output logic  legal_o
);
  logic  len_ok, top_ok, taps_fit, seed_nz, seed_fit;
  word_t am;

  always_comb begin
    am       = active_mask(len_i);
    len_ok   = (len_i >= len_t'(2)) && (len_i <= len_t'(MAX_W));
    top_ok   = |(taps_i & top_bit(len_i));
    taps_fit = ((taps_i & ~am) == '0);
    seed_nz  = (seed_i != '0);
    seed_fit = ((seed_i & ~am) == '0);
    legal_o  = len_ok && top_ok && taps_fit && seed_nz && seed_fit;
  end
endmodule

// File: rtl/lfsr_next.sv
module lfsr_next
  import lfsr_pkg::*;
(
  input  word_t cur_i,
  input  len_t  len_i,
  input  word_t taps_i,
  input  logic  galois_i,
  output word_t nxt_o
);
  word_t sh, am, gmask, nxt_f, nxt_g;
  logic  fb;

  always_comb begin
    am    = active_mask(len_i);
    sh    = cur_i >> 1;
    fb    = ^(cur_i & (taps_i | word_t'(1)) & am);
    nxt_f = sh | (fb ? top_bit(len_i) : '0);
    gmask = taps_i & ~word_t'(1) & am;
  end

  // internal XOR chain: one gate per stage
  for (genvar i = 0; i < MAX_W; i++) begin : g_int
    assign nxt_g[i] = sh[i] ^ (cur_i[0] & gmask[i]);
  end

  assign nxt_o = galois_i ? nxt_g : nxt_f;
endmodule

// File: rtl/lfsr_stepper.sv
module lfsr_stepper
  import lfsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  len,
  input  logic [15:0] taps,
  input  logic        galois,
  input  logic [15:0] seed,
  input  logic        load,
  input  logic        step,
  output logic [15:0] state,
  output logic        bit_out,
  output logic        bit_vld,
  output logic        err
);
  word_t st_q, taps_q, nxt;
  len_t  len_q;
  logic  gal_q, armed_q, err_q, bo_q, bv_q, legal;

  lfsr_cfg_check u_chk (
    .len_i(len), .taps_i(taps), .seed_i(seed), .legal_o(legal)
  );

  lfsr_next u_nxt (
    .cur_i(st_q), .len_i(len_q), .taps_i(taps_q), .galois_i(gal_q), .nxt_o(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      taps_q  <= '0;
      len_q   <= '0;
      gal_q   <= 1'b0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
      bo_q    <= 1'b0;
      bv_q    <= 1'b0;
    end else begin
      bv_q <= 1'b0;
      if (load) begin
        if (legal) begin
          st_q    <= seed;
          taps_q  <= taps;
          len_q   <= len;
          gal_q   <= galois;
          armed_q <= 1'b1;
          err_q   <= 1'b0;
        end else begin
          armed_q <= 1'b0;
          err_q   <= 1'b1;
        end
      end else if (step && armed_q) begin
        st_q <= nxt;
        bo_q <= st_q[0];
        bv_q <= 1'b1;
      end
    end
  end

  assign state   = st_q;
  assign bit_out = bo_q;
  assign bit_vld = bv_q;
  assign err     = err_q;

  p_load_seed_r2: assert property (@(posedge clk) disable iff (rst)
    load && legal |=> (state == $past(seed)) && !err);
  p_bad_load_r3: assert property (@(posedge clk) disable iff (rst)
    load && !legal |=> err && $stable(state));
  p_err_blocks_step_r5: assert property (@(posedge clk) disable iff (rst)
    err && !load |=> $stable(state) && !bit_vld);
  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> $past(step) && !$past(load));
  p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> !bit_vld);
  p_no_lockup_r7: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> state != '0);
endmodule

// File: tb/sim_lfsr_stepper.sv
module sim_lfsr_stepper;
  logic        clk = 0, rst = 1;
  logic [4:0]  len = 0;
  logic [15:0] taps = 0, seed = 0;
  logic        galois = 0, load = 0, step = 0;
  logic [15:0] state;
  logic        bit_out, bit_vld, err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [15:0] m_st = 0, m_taps = 0;
  int          m_len = 0;
  bit          m_gal = 0, m_armed = 0, m_err = 0, m_bo = 0, m_bv = 0;

  lfsr_stepper u0 (.clk(clk), .rst(rst), .len(len), .taps(taps), .galois(galois),
    .seed(seed), .load(load), .step(step), .state(state), .bit_out(bit_out),
    .bit_vld(bit_vld), .err(err));

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_legal(int n, logic [15:0] t, logic [15:0] s);
    if (n < 2 || n > 16) return 0;
    if (!t[n-1]) return 0;
    if ((32'(t) >> n) != 0) return 0;
    if (s == 0 || (32'(s) >> n) != 0) return 0;
    return 1;
  endfunction

  function automatic logic [15:0] ref_next(logic [15:0] s, int n, logic [15:0] t, bit g);
    logic [15:0] r;
    bit fb;
    r = s >> 1;
    if (!g) begin
      fb = s[0];
      for (int i = 1; i < n; i++) if (t[i]) fb ^= s[i];
      r[n-1] = fb;
    end else if (s[0]) begin
      for (int i = 1; i < n; i++) if (t[i]) r[i] = ~r[i];
    end
    return r;
  endfunction

  // one clock: inputs already driven at negedge; model updates; compare at next negedge
  task automatic cyc(input string req);
    @(posedge clk);
    m_bv = 0;
    if (rst) begin
      m_st = 0; m_armed = 0; m_err = 0; m_bo = 0;
    end else if (load) begin
      if (ref_legal(int'(len), taps, seed)) begin
        m_st = seed; m_taps = taps; m_len = int'(len); m_gal = galois;
        m_armed = 1; m_err = 0;
      end else begin
        m_armed = 0; m_err = 1;
      end
    end else if (step && m_armed) begin
      m_bo = m_st[0]; m_bv = 1;
      m_st = ref_next(m_st, m_len, m_taps, m_gal);
    end
    @(negedge clk);
    check({req, " state"}, int'(state), int'(m_st));
    check({req, " err"}, int'(err), int'(m_err));
    check({req, " vld"}, int'(bit_vld), int'(m_bv));
    if (m_bv) check({req, " bit"}, int'(bit_out), int'(m_bo));
  endtask

  task automatic do_load(input int n, input logic [15:0] t, input logic [15:0] s,
                         input bit g, input string req);
    len = 5'(n); taps = t; seed = s; galois = g; load = 1; step = 0;
    cyc(req);
    load = 0;
  endtask

  task automatic do_step(input string req);
    step = 1; load = 0;
    cyc(req);
    step = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] stream;
    void'($urandom(32'h1234_5678));
    @(negedge clk);
    cyc("R1 reset"); cyc("R1 reset");
    rst = 0;
    @(negedge clk);
    check("R1 state", int'(state), 0);
    check("R1 err", int'(err), 0);
    check("R1 vld", int'(bit_vld), 0);

    // R5: stepping before any load
    do_step("R5 unloaded");
    check("R5 unloaded state", int'(state), 0);

    // R7 directed: n=8 seed 225 taps {3,4,8}
    do_load(8, 16'h008C, 16'd225, 0, "R2 load fib");
    check("R2 seed", int'(state), 225);
    stream = 0;
    for (int k = 0; k < 16; k++) begin
      do_step("R7 fib");
      if (k == 0) check("R7 first next", int'(state), 112);
      stream = {stream[14:0], bit_out};
    end
    check("R7 fib stream", int'(stream), 16'b1000011100111100);

    // R8 directed: n=16 seed ACE1 taps {11,13,14,16}
    do_load(16, 16'hB400, 16'hACE1, 1, "R2 load gal");
    stream = 0;
    for (int k = 0; k < 8; k++) begin
      do_step("R8 gal");
      stream = {stream[14:0], bit_out};
    end
    check("R8 gal stream", int'(stream[7:0]), 8'b10000111);

    // R3: zero seed and oversized seed
    do_load(8, 16'h0080, 16'h0000, 0, "R3 zero seed");
    check("R3 err", int'(err), 1);
    do_step("R5 err step");
    do_load(8, 16'h0080, 16'h0100, 0, "R3 wide seed");
    // R4: bad length, missing top tap, stray tap
    do_load(1, 16'h0001, 16'h0001, 0, "R4 len1");
    do_load(17, 16'h0001, 16'h0001, 0, "R4 len17");
    do_load(8, 16'h0040, 16'h0011, 0, "R4 no top");
    do_load(8, 16'h0180, 16'h0011, 0, "R4 stray");
    do_step("R5 err step");
    // R10: load and step together
    len = 5'd4; taps = 16'h000C; seed = 16'h0009; galois = 0; load = 1; step = 1;
    cyc("R10 load+step");
    load = 0; step = 0;
    check("R10 state", int'(state), 9);
    // R9: change config between steps
    len = 5'd16; taps = 16'hFFFF; galois = 1;
    for (int k = 0; k < 6; k++) do_step("R9 cfg ignored");

    // constrained random
    for (int it = 0; it < 3000; it++) begin
      int r, n;
      logic [15:0] msk, t, s;
      r = int'($urandom % 100);
      len = 5'($urandom); taps = 16'($urandom); galois = 1'($urandom);
      seed = 16'($urandom);
      if (r < 6) begin
        n = 2 + int'($urandom % 15);
        msk = 16'((32'h1 << n) - 1);
        t = (16'($urandom) & msk) | 16'(32'h1 << (n - 1));
        s = 16'($urandom) & msk;
        if (s == 0) s = 1;
        case ($urandom % 6)
          0: s = 0;
          1: s = (n < 16) ? (s | 16'(32'h1 << n)) : 16'h0;
          2: t = t & ~16'(32'h1 << (n - 1));
          3: n = 0;
          default: ;
        endcase
        do_load(n, t, s, 1'($urandom), "R2/R3/R4 rand load");
      end else if (r < 90) begin
        do_step("R7/R8/R9 rand step");
      end else begin
        load = 1'($urandom); step = 1'($urandom);
        cyc("R10 rand mix");
        load = 0; step = 0;
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule